// File: doc/BRIEF.md
# PWM Prescaler Tick Generator

This block sits beside a group of PWM channels and turns the master clock into a set of single-cycle enable pulses that the channels use to advance their counters. A free-running binary counter provides eleven fixed taps. Tap 0 is asserted on every master-clock cycle. Tap k pulses once every 2^k cycles, so the slowest tap runs at one pulse per 1024 cycles. Every output is a clock enable. None is a derived clock, so all downstream logic stays in the master clock domain.

Two independent linear dividers, A and B, each pick one fixed tap with a 4-bit select value. Each then divides that tap further by an 8-bit factor. A divider is configured by presenting select and factor together with a one-cycle write strobe. A factor of zero switches that divider off. A global enable pin stands in for the power-management clock gate. While it is low, the counter freezes and only tap 0 keeps pulsing.

All pins are plain control and status signals. The block carries no data stream, so it has no valid/ready handshake.

Top module: `pwm_tick_gen`

## Requirements
- R1: `tap_o[0]` is high in every cycle, including during reset and while `gate_en_i` is low.
- R2: For k from 1 to 10, `tap_o[k]` is high exactly in the enabled cycles where the low k bits of the count of enabled cycles since reset are all ones. It therefore pulses once every 2^k enabled cycles, with the first pulse at enabled cycle 2^k-1.
- R3: After reset, `tap_o[10:1]` is low, and both dividers hold select 0 and factor 0. `tick_a_o` and `tick_b_o` stay low until a write.
- R4: While `gate_en_i` is low, `tap_o[10:1]` is low and the tap counter holds its value. The counter resumes from that value when the enable returns.
- R5: A divider whose stored factor is 0 never asserts its tick.
- R6: Select values 0 to 10 choose `tap_o[select]`. Select values 11 to 15 are reserved, and a divider holding one never ticks.
- R7: With stored factor N from 1 to 255, the tick is high on every N-th pulse of the selected tap, in the same cycle as that pulse. With N = 1, the tick equals the selected tap.
- R8: A write strobe stores select and factor and restarts the divider. The tick is low in the write cycle. The first tick then falls on the N-th selected-tap pulse after the write cycle.
- R9: Dividers A and B are independent. A write to one leaves the other's ticks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gate_en_i | input | 1 | Master-clock enable from power management; low freezes the divided taps |
| a_wr_i | input | 1 | Write strobe for divider A |
| a_sel_i | input | 4 | Tap select for divider A (0..10 valid) |
| a_factor_i | input | 8 | Linear divide factor for divider A (0 = off) |
| b_wr_i | input | 1 | Write strobe for divider B |
| b_sel_i | input | 4 | Tap select for divider B (0..10 valid) |
| b_factor_i | input | 8 | Linear divide factor for divider B (0 = off) |
| tap_o | output | 11 | Fixed power-of-two enable taps, bit k = divide by 2^k |
| tick_a_o | output | 1 | Enable pulse from divider A |
| tick_b_o | output | 1 | Enable pulse from divider B |

## Verification
The hardest situation to reach is a divider restart that lands at an arbitrary phase of a slow tap while the gate is dropping cycles. Both the restart and the gating shift every later tick. The stimulus keeps the tap counter free-running across all divider configurations, so each write lands at a different counter phase. It drops the gate on a fixed cycle pattern during the sweep and rewrites divider A with its current values halfway through each run. A bench-side model counts enabled cycles and selected-tap pulses, and it predicts every tap and tick in every cycle.

// File: rtl/pwm_tick_pkg.sv
`timescale 1ns/1ps
package pwm_tick_pkg;
  localparam int NUM_TAPS = 11;
  localparam int SEL_W    = 4;
  localparam int DIV_W    = 8;
  localparam int NUM_DIV  = 2;

  typedef struct packed {
    logic             wr;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] factor;
  } div_cfg_t;
endpackage

// File: rtl/pwm_tap_counter.sv
`timescale 1ns/1ps
module pwm_tap_counter #(
  parameter int NUM_TAPS = pwm_tick_pkg::NUM_TAPS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                gate_en_i,
  output logic [NUM_TAPS-1:0] tap_o
);
  localparam int CW = NUM_TAPS - 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (gate_en_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // The undivided tap follows the master clock itself.
  assign tap_o[0] = 1'b1;

  for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
    assign tap_o[k] = gate_en_i & (&cnt_q[k-1:0]);

    // Each slower tap only fires together with the next faster one.
    p_nested_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      tap_o[k] |-> tap_o[k-1]);
  end

  p_advance_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_i |=> (cnt_q == $past(cnt_q) + CW'(1)));

  p_hold_gated_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |=> $stable(cnt_q));

  p_gated_taps_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |-> (tap_o[NUM_TAPS-1:1] == '0));
endmodule

// File: rtl/pwm_linear_div.sv
`timescale 1ns/1ps
module pwm_linear_div #(
  parameter int NUM_TAPS = pwm_tick_pkg::NUM_TAPS,
  parameter int SEL_W    = pwm_tick_pkg::SEL_W,
  parameter int DIV_W    = pwm_tick_pkg::DIV_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TAPS-1:0] taps_i,
  input  logic                wr_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [DIV_W-1:0]    factor_i,
  output logic                tick_o
);
  localparam int NSEL = 2 ** SEL_W;

  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] fac_q;
  logic [DIV_W-1:0] cnt_q;
  logic [NSEL-1:0]  taps_pad;
  logic             sel_pulse;
  logic             active;
  logic             last;

  // Reserved select codes land on zero padding and never pulse.
  assign taps_pad  = NSEL'(taps_i);
  assign sel_pulse = taps_pad[sel_q];
  assign active    = (fac_q != '0);
  assign last      = (cnt_q == DIV_W'(1));
  assign tick_o    = ~wr_i & sel_pulse & active & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      fac_q <= '0;
      cnt_q <= '0;
    end else if (wr_i) begin
      sel_q <= sel_i;
      fac_q <= factor_i;
      cnt_q <= factor_i;
    end else if (sel_pulse && active) begin
      cnt_q <= last ? fac_q : cnt_q - DIV_W'(1);
    end
  end

  p_zero_off_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fac_q == '0) |-> !tick_o);

  p_reserved_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sel_q) >= NUM_TAPS) |-> !tick_o);

  p_count_range_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (cnt_q != '0 && cnt_q <= fac_q));

  p_reload_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == fac_q));

  p_write_quiet_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !tick_o);

  p_restart_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(factor_i)));
endmodule

// File: rtl/pwm_tick_gen.sv
`timescale 1ns/1ps
module pwm_tick_gen #(
  parameter int NUM_TAPS = pwm_tick_pkg::NUM_TAPS,
  parameter int SEL_W    = pwm_tick_pkg::SEL_W,
  parameter int DIV_W    = pwm_tick_pkg::DIV_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                gate_en_i,
  input  logic                a_wr_i,
  input  logic [SEL_W-1:0]    a_sel_i,
  input  logic [DIV_W-1:0]    a_factor_i,
  input  logic                b_wr_i,
  input  logic [SEL_W-1:0]    b_sel_i,
  input  logic [DIV_W-1:0]    b_factor_i,
  output logic [NUM_TAPS-1:0] tap_o,
  output logic                tick_a_o,
  output logic                tick_b_o
);
  localparam int NUM_DIV = pwm_tick_pkg::NUM_DIV;

  logic [NUM_TAPS-1:0] taps;
  logic [NUM_DIV-1:0]  wr;
  logic [SEL_W-1:0]    sel [NUM_DIV];
  logic [DIV_W-1:0]    fac [NUM_DIV];
  logic [NUM_DIV-1:0]  tick;

  pwm_tap_counter #(.NUM_TAPS(NUM_TAPS)) u_taps (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gate_en_i (gate_en_i),
    .tap_o     (taps)
  );

  assign wr[0]  = a_wr_i;
  assign sel[0] = a_sel_i;
  assign fac[0] = a_factor_i;
  assign wr[1]  = b_wr_i;
  assign sel[1] = b_sel_i;
  assign fac[1] = b_factor_i;

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    pwm_linear_div #(
      .NUM_TAPS (NUM_TAPS),
      .SEL_W    (SEL_W),
      .DIV_W    (DIV_W)
    ) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .taps_i   (taps),
      .wr_i     (wr[i]),
      .sel_i    (sel[i]),
      .factor_i (fac[i]),
      .tick_o   (tick[i])
    );
  end

  assign tap_o    = taps;
  assign tick_a_o = tick[0];
  assign tick_b_o = tick[1];
endmodule

// File: tb/pwm_tick_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_tick_gen_tb_top;
  localparam int NT = 11;
  localparam int MAX_CYCLES = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          gate = 1'b0;
  logic          a_wr = 1'b0, b_wr = 1'b0;
  logic [3:0]    a_sel = '0, b_sel = '0;
  logic [7:0]    a_fac = '0, b_fac = '0;
  logic [NT-1:0] tap;
  logic          tick_a, tick_b;

  int n_cmp = 0;
  int n_bad = 0;
  // Bench model: enabled-cycle count and per-divider stored state.
  int e_m = 0;
  int da = 0, pa = 0, ma = 0;
  int db = 0, pb = 0, mb = 0;

  always #2.5 clk = ~clk;

  pwm_tick_gen dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .gate_en_i  (gate),
    .a_wr_i     (a_wr),
    .a_sel_i    (a_sel),
    .a_factor_i (a_fac),
    .b_wr_i     (b_wr),
    .b_sel_i    (b_sel),
    .b_factor_i (b_fac),
    .tap_o      (tap),
    .tick_a_o   (tick_a),
    .tick_b_o   (tick_b)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit g, bit wa, int sa, int fa, bit wb, int sb, int fb);
    logic [NT-1:0] et;
    bit sela, selb, eta, etb;
    @(negedge clk);
    gate  = g;
    a_wr  = wa; a_sel = sa[3:0]; a_fac = fa[7:0];
    b_wr  = wb; b_sel = sb[3:0]; b_fac = fb[7:0];
    #1;
    et[0] = 1'b1;
    for (int k = 1; k < NT; k++)
      et[k] = g && ((e_m % (1 << k)) == (1 << k) - 1);
    sela = (pa < NT) ? et[pa] : 1'b0;
    selb = (pb < NT) ? et[pb] : 1'b0;
    eta  = !wa && da != 0 && sela && (ma + 1 == da);
    etb  = !wb && db != 0 && selb && (mb + 1 == db);
    check(tag, "taps", int'(tap), int'(et));
    check(tag, "tick_a", int'(tick_a), int'(eta));
    check(tag, "tick_b", int'(tick_b), int'(etb));
    if (g) e_m = (e_m + 1) % 1024;
    if (wa) begin da = fa; pa = sa; ma = 0; end
    else if (sela && da != 0) ma = (ma + 1 == da) ? 0 : ma + 1;
    if (wb) begin db = fb; pb = sb; mb = 0; end
    else if (selb && db != 0) mb = (mb + 1 == db) ? 0 : mb + 1;
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1/R3: reset state, only the undivided tap is active
    repeat (3) @(negedge clk);
    #1;
    check("R1/R3", "taps in reset", int'(tap), 1);
    check("R3", "tick_a in reset", int'(tick_a), 0);
    check("R3", "tick_b in reset", int'(tick_b), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: dividers start switched off
    for (int i = 0; i < 20; i++) step("R3", 1, 0, 0, 0, 0, 0, 0);

    // R1/R2: free-running taps across more than one full counter wrap
    for (int i = 0; i < 2100; i++) step("R1/R2", 1, 0, 0, 0, 0, 0, 0);

    // R4: sparse gate drops and a long gated stretch
    for (int i = 0; i < 600; i++)
      step("R4", (i % 5 != 2) && !(i >= 200 && i < 260), 0, 0, 0, 0, 0, 0);

    // R7/R8/R9: sweep of selects and factors on both dividers with gating
    for (int p = 0; p < 5; p++) begin
      for (int n = 1; n <= 8; n++) begin
        int run;
        run = 3 * (1 << p) * n + 3;
        step("R8", 1, 1, p, n, 1, 4 - p, 9 - n);
        for (int i = 0; i < run; i++) begin
          if (i == run / 2)
            step("R8/R9", (i % 11 != 4), 1, p, n, 0, 0, 0);
          else
            step("R7/R9", (i % 11 != 4), 0, 0, 0, 0, 0, 0);
        end
      end
    end

    // R6: reserved selects stay silent while B passes tap 0 through
    for (int s = 11; s < 16; s++) begin
      step("R6", 1, 1, s, 3, 1, 0, 1);
      for (int i = 0; i < 60; i++) step("R6", 1, 0, 0, 0, 0, 0, 0);
    end

    // R5: zero factor on a tap that pulses every cycle
    step("R5", 1, 1, 0, 0, 1, 3, 0);
    for (int i = 0; i < 50; i++) step("R5", 1, 0, 0, 0, 0, 0, 0);

    // R6/R7: slowest taps
    step("R6/R7", 1, 1, 10, 2, 1, 9, 1);
    for (int i = 0; i < 4200; i++) step("R6/R7", 1, 0, 0, 0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule